// File: doc/BRIEF.md
# Trailing bit manipulation unit

This execution unit applies one of nine bit-twiddling operations to a general-purpose register operand. Each operation targets either the lowest set bit or the lowest clear bit of the source, and each is formed by combining the source, its complement, and the source incremented or decremented by one. A single incrementer and a single decrementer are shared by all nine combine functions, and the opcode selects among them.

An operand is accepted when `in_valid` and `in_ready` are both high. The result and three status flags are registered and appear, with `out_valid`, one clock later. A size input picks 64-bit or 32-bit operation. In 32-bit mode only the low half of the source is used, the arithmetic wraps at 32 bits, and the upper half of the result is forced to zero.

Top module: `trailbit_alu`

## Requirements
- R1: Opcodes 0, 1 and 2 compute, in that order, `s | (s-1)`, `~s | (s-1)` and `~s & (s-1)`, where s is the source at the selected width. For example, 64-bit opcode 2 on 0x0040201008040200 gives 0x00000000000001FF.
- R2: Opcodes 3, 4 and 5 compute, in that order, `s & (s+1)`, `s | ~(s+1)` and `~s & (s+1)`.
- R3: Opcodes 6, 7 and 8 compute, in that order, `s ^ (s+1)`, `s | (s+1)` and `~s | (s+1)`.
- R4: When `in_wide` is 0 (32-bit mode), source bits 63:32 are ignored, the increment and decrement wrap at 32 bits, and result bits 63:32 are 0. When `in_wide` is 1, all 64 bits are used.
- R5: For a defined opcode, `out_zero` is 1 exactly when the result is all zeros.
- R6: `out_carry` is 1 when the source at the selected width is all zeros for opcodes 0 to 2, or all ones for opcodes 3 to 8; otherwise it is 0.
- R7: Opcodes 9 to 15 are undefined. They give a result of 0 with `out_err` at 1 and `out_zero` and `out_carry` at 0. For a defined opcode, `out_err` is 0.
- R8: An operand accepted on a clock edge sets `out_valid` to 1 and updates the result and flags at that edge. At an edge with no accepted operand, `out_valid` goes to 0 and the result holds its value.
- R9: While reset is asserted, `in_ready` and `out_valid` are 0, as are the result and all three flags. `in_ready` rises at the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Unit can accept an operand |
| in_op | input | 4 | Operation select (0 to 8 defined) |
| in_wide | input | 1 | 1 selects 64-bit operation, 0 selects 32-bit |
| in_src | input | XLEN (64) | Source operand |
| out_valid | output | 1 | Result is valid this cycle |
| out_result | output | XLEN (64) | Registered result |
| out_zero | output | 1 | Result is all zeros |
| out_carry | output | 1 | Source has no target bit (all zeros or all ones) |
| out_err | output | 1 | Opcode undefined |

## Verification
The bench sweeps every opcode at both sizes over walking-one and walking-zero sources, together with all-zeros, all-ones and mixed patterns. This exposes any combine that uses the wrong carry-chain end: for example, a mask that includes the lowest one bit is caught when the source has a single bit set. In 32-bit mode it drives garbage in the upper source half and sources of 0xFFFFFFFF. A design that lets the upper half leak in, or that fails to wrap at 32 bits, would give a nonzero upper result or the wrong carry flag there. The undefined opcodes are checked for a zero result with the error flag set. Idle cycles are checked to confirm that the valid flag drops and that the result does not move.

// File: rtl/trailbit_alu.sv
module trailbit_alu #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [3:0]      in_op,
  input  logic            in_wide,
  input  logic [XLEN-1:0] in_src,
  output logic            out_valid,
  output logic [XLEN-1:0] out_result,
  output logic            out_zero,
  output logic            out_carry,
  output logic            out_err
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] mask, s, inc, dec, pre, res;
  logic            known, s_zero, s_ones, carry_n, take;

  assign mask   = in_wide ? {XLEN{1'b1}} : {{(XLEN-HALF){1'b0}}, {HALF{1'b1}}};
  assign s      = in_src & mask;
  assign inc    = s + 1'b1;
  assign dec    = s - 1'b1;
  assign s_zero = (s == '0);
  assign s_ones = &(s | ~mask);
  assign take   = in_valid & in_ready;

  always_comb begin
    pre   = '0;
    known = 1'b1;
    case (in_op)
      4'd0: pre = s | dec;
      4'd1: pre = ~s | dec;
      4'd2: pre = ~s & dec;
      4'd3: pre = s & inc;
      4'd4: pre = s | ~inc;
      4'd5: pre = ~s & inc;
      4'd6: pre = s ^ inc;
      4'd7: pre = s | inc;
      4'd8: pre = ~s | inc;
      default: known = 1'b0;
    endcase
  end

  assign res     = pre & mask;
  assign carry_n = known & ((in_op < 4'd3) ? s_zero : s_ones);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_ready   <= 1'b0;
      out_valid  <= 1'b0;
      out_result <= '0;
      out_zero   <= 1'b0;
      out_carry  <= 1'b0;
      out_err    <= 1'b0;
    end else begin
      in_ready  <= 1'b1;
      out_valid <= take;
      if (take) begin
        out_result <= res;
        out_zero   <= known & (res == '0);
        out_carry  <= carry_n;
        out_err    <= ~known;
      end
    end
  end
endmodule

// File: rtl/trailbit_alu_chk.sv
module trailbit_alu_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [3:0]      in_op,
  input logic            in_wide,
  input logic [XLEN-1:0] in_src,
  input logic            out_valid,
  input logic [XLEN-1:0] out_result,
  input logic            out_zero,
  input logic            out_carry,
  input logic            out_err
);
  localparam int HALF = XLEN / 2;

  p_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> (!out_valid && $stable(out_result)));

  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_wide) |=> (out_result[XLEN-1:HALF] == '0));

  p_bad_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op > 4'd8) |=>
      (out_err && out_result == '0 && !out_zero && !out_carry));

  p_tz_disjoint_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 4'd2) |=> ((out_result & $past(in_src)) == '0));

  p_zero_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_err) |-> (out_zero == (out_result == '0)));

  p_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_wide && in_src == '0 && in_op < 4'd3) |=> out_carry);
endmodule

bind trailbit_alu trailbit_alu_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_trailbit_alu.sv
`timescale 1ns/1ps
module sim_trailbit_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = 4'd0;
  logic        in_wide = 1'b1;
  logic [63:0] in_src = 64'd0;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_zero, out_carry, out_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  trailbit_alu #(.XLEN(64)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_wide(in_wide), .in_src(in_src),
    .out_valid(out_valid), .out_result(out_result),
    .out_zero(out_zero), .out_carry(out_carry), .out_err(out_err)
  );

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [3:0] op, input logic wide, input logic [63:0] src);
    logic [63:0] a, p, m;
    logic [31:0] b, q, n;
    a = src; p = src + 64'd1; m = src - 64'd1;
    b = src[31:0]; q = src[31:0] + 32'd1; n = src[31:0] - 32'd1;
    if (wide) begin
      case (op)
        4'd0: return a | m;
        4'd1: return ~a | m;
        4'd2: return ~a & m;
        4'd3: return a & p;
        4'd4: return a | ~p;
        4'd5: return ~a & p;
        4'd6: return a ^ p;
        4'd7: return a | p;
        4'd8: return ~a | p;
        default: return 64'd0;
      endcase
    end else begin
      case (op)
        4'd0: return {32'd0, b | n};
        4'd1: return {32'd0, ~b | n};
        4'd2: return {32'd0, ~b & n};
        4'd3: return {32'd0, b & q};
        4'd4: return {32'd0, b | ~q};
        4'd5: return {32'd0, ~b & q};
        4'd6: return {32'd0, b ^ q};
        4'd7: return {32'd0, b | q};
        4'd8: return {32'd0, ~b | q};
        default: return 64'd0;
      endcase
    end
  endfunction

  function automatic logic [63:0] pattern(input int i);
    if (i < 64) return 64'd1 << i;
    if (i < 128) return ~(64'd1 << (i - 64));
    case (i)
      128: return 64'd0;
      129: return ~64'd0;
      130: return 64'h0040201008040200;
      131: return 64'h80C0E0F0F8FCFEFF;
      132: return 64'h00000000FFFFFFFF;
      133: return 64'hA5A5A5A5FFFFFFFF;
      134: return 64'hDEADBEEF00000000;
      135: return 64'hFFFFFFFF00000000;
      136: return 64'h123456789ABCDEF0;
      137: return 64'h5555555555555555;
      138: return 64'hCAFEF00D0000FF00;
      default: return 64'h00000000FFFFFFFE;
    endcase
  endfunction

  task automatic run(input logic [3:0] op, input logic wide, input logic [63:0] src);
    logic [63:0] e;
    logic        ez, ec, ee;
    logic [63:0] s;
    string       tag;
    e  = model(op, wide, src);
    s  = wide ? src : {32'd0, src[31:0]};
    ee = (op > 4'd8);
    ez = !ee && (e == 64'd0);
    ec = ee ? 1'b0 : ((op < 4'd3) ? (s == 64'd0)
                                  : (wide ? (s == ~64'd0) : (s[31:0] == 32'hFFFFFFFF)));
    if (!wide) tag = "R4";
    else if (op < 4'd3) tag = "R1";
    else if (op < 4'd6) tag = "R2";
    else if (op < 4'd9) tag = "R3";
    else tag = "R7";
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_wide = wide; in_src = src;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, $sformatf("result op=%0d wide=%0d src=%h", op, wide, src), out_result, e);
    check("R5", "zero flag", {63'd0, out_zero}, {63'd0, ez});
    check("R6", "carry flag", {63'd0, out_carry}, {63'd0, ec});
    check("R7", "error flag", {63'd0, out_err}, {63'd0, ee});
    check("R8", "valid after accept", {63'd0, out_valid}, 64'd1);
  endtask

  initial begin
    logic [63:0] held;
    #1;
    @(negedge clk);
    check("R9", "in_ready in reset", {63'd0, in_ready}, 64'd0);
    check("R9", "out_valid in reset", {63'd0, out_valid}, 64'd0);
    check("R9", "result in reset", out_result, 64'd0);
    check("R9", "flags in reset", {61'd0, out_zero, out_carry, out_err}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "in_ready after reset", {63'd0, in_ready}, 64'd1);
    check("R8", "no valid without accept", {63'd0, out_valid}, 64'd0);

    run(4'd2, 1'b1, 64'h0040201008040200);
    check("R1", "known trailing-zero mask", out_result, 64'h00000000000001FF);

    for (int op = 0; op < 16; op++)
      for (int w = 0; w < 2; w++)
        for (int i = 0; i < 140; i++)
          run(op[3:0], w[0], pattern(i));

    run(4'd7, 1'b0, 64'hFFFF0000_00000001);
    held = out_result;
    @(negedge clk);
    check("R8", "valid drops when idle", {63'd0, out_valid}, 64'd0);
    check("R8", "result holds when idle", out_result, held);
    in_valid = 1'b1; in_op = 4'd3;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", "back-to-back accept valid", {63'd0, out_valid}, 64'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule